// File: doc/BRIEF.md
# Program Sequencer with Conditional Branching and Return Stack

This block is the instruction-flow front end of a small fixed-point signal processor. Every clock cycle it presents its 14-bit program counter as the program ROM address and takes in the 24-bit word read back on the same cycle. The two top bits of that word give the instruction class. The block raises the matching class strobe so that the neighbouring datapath blocks (ALU, register moves, immediate loads) can act on the word. The sequencer itself only decides where the next instruction comes from.

For jump-class words it builds the destination from a bank field and a next-address field. The page bit (bit 13) is taken from the already incremented counter unless the branch code forces it. The branch condition can test any of six flags in either of two accumulator flag sets, a few values of the data-pointer low nibble, or a host-request bit. Call codes save the return address on an eight-entry hardware stack whose pointer wraps around. A return-class word pops that stack once its operation has been issued.

Top module: `dsp_seq`

## Requirements
- R1: While `rst_n` is low the program counter reads 0, and the return stack pointer starts empty.
- R2: `rom_data[23:22]` selects exactly one strobe: 0 `is_op`, 1 `is_ret`, 2 `is_jmp`, 3 `is_ld`. An op or load word advances the counter by one, modulo 2^14 (0x3FFF goes to 0).
- R3: For a jump word, `rom_data[21:13]` is the branch code, `rom_data[12:2]` the next address and `rom_data[1:0]` the bank. The target is {bit 13 of PC+1, bank, next address}, so a taken jump at 0x1FFF lands in the upper page.
- R4: Code 0x000 loads the counter from `so_val`. Code 0x100 jumps to the target with bit 13 cleared, and code 0x101 jumps to it with bit 13 set.
- R5: Codes 0x140 and 0x141 push PC+1 onto the return stack, then jump to the target with bit 13 cleared (0x140) or set (0x141).
- R6: The even codes 0x080 to 0x0AE each test one flag. Flag vectors use bit 0 carry, bit 1 zero, bit 2 overflow0, bit 3 overflow1, bit 4 sign0 and bit 5 sign1. Write k = (code-0x080)/2. The flag tested is bit k/4, of `flags_b` when (k/2) is odd and of `flags_a` otherwise, and the branch is taken when that bit equals k mod 2.
- R7: Codes 0x0B0, 0x0B1, 0x0B2 and 0x0B3 branch when `dp_low` is 0, is not 0, is 0xF, and is not 0xF, respectively.
- R8: Code 0x0BC branches when `req_flag` is 0, and code 0x0BE branches when it is 1.
- R9: Any other branch code, and any condition that is not met, gives PC+1.
- R10: A return word raises `stk_pop` and loads the counter from the most recent push. The stack holds 8 entries with a wrapping pointer, so a ninth push overwrites the oldest entry and pops read back in last-in, first-out order modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_data | input | 24 | Instruction word read at address `pc` |
| flags_a | input | 6 | Accumulator A flags (carry, zero, ov0, ov1, sign0, sign1 at bits 0..5) |
| flags_b | input | 6 | Accumulator B flags, same layout |
| dp_low | input | 4 | Low nibble of the data pointer |
| req_flag | input | 1 | Host request flag |
| so_val | input | 14 | Serial-out register value used as an indirect target |
| pc | output | 14 | Program counter and ROM address |
| is_op | output | 1 | Current word is a plain operation |
| is_ret | output | 1 | Current word is an operation with return |
| is_jmp | output | 1 | Current word is a jump |
| is_ld | output | 1 | Current word is an immediate load |
| stk_pop | output | 1 | Return stack pop this cycle |

## Verification
All 512 branch codes are issued under twelve different arithmetic mixes of the two flag vectors, the data-pointer nibble and the request bit. This tells the flag index apart from the bank select and from the polarity, and it separates decoded codes from undefined ones. Before each tested jump, a forced-page jump places the counter in the lower or the upper page, so both values of the inherited bit 13 reach the target. The page-carry corner at 0x1FFF and the counter wrap at 0x3FFF get dedicated words. A run of nine calls followed by nine returns, with ops and loads between them, exposes a faulty wrap or faulty last-in, first-out order in the stack.

// File: rtl/dsp_seq.sv
`timescale 1ns/1ps
module dsp_seq #(
  parameter int STK_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] rom_data,
  input  logic [5:0]  flags_a,
  input  logic [5:0]  flags_b,
  input  logic [3:0]  dp_low,
  input  logic        req_flag,
  input  logic [13:0] so_val,
  output logic [13:0] pc,
  output logic        is_op,
  output logic        is_ret,
  output logic        is_jmp,
  output logic        is_ld,
  output logic        stk_pop
);
  localparam int PC_W = 14;
  localparam int SP_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
  localparam logic [SP_W-1:0] SP_TOP = SP_W'(STK_DEPTH - 1);
  localparam int F_C = 0, F_Z = 1, F_V0 = 2, F_V1 = 3, F_S0 = 4, F_S1 = 5;

  logic [PC_W-1:0] stk [STK_DEPTH];
  logic [SP_W-1:0] sp, sp_dec;
  logic [PC_W-1:0] pc_nxt;
  logic take, push;

  wire [1:0]      cls    = rom_data[23:22];
  wire [8:0]      code   = rom_data[21:13];
  wire [PC_W-1:0] pc_inc = pc + 14'd1;
  wire [PC_W-1:0] tgt    = {pc_inc[PC_W-1], rom_data[1:0], rom_data[12:2]};

  assign is_op   = (cls == 2'd0);
  assign is_ret  = (cls == 2'd1);
  assign is_jmp  = (cls == 2'd2);
  assign is_ld   = (cls == 2'd3);
  assign stk_pop = is_ret;
  assign sp_dec  = (sp == '0) ? SP_TOP : sp - 1'b1;

  always_comb begin
    take   = 1'b0;
    push   = 1'b0;
    pc_nxt = pc_inc;
    if (is_ret) begin
      pc_nxt = stk[sp_dec];
    end else if (is_jmp) begin
      case (code)
        9'h000: pc_nxt = so_val;
        9'h100: pc_nxt = {1'b0, tgt[PC_W-2:0]};
        9'h101: pc_nxt = {1'b1, tgt[PC_W-2:0]};
        9'h140: begin push = 1'b1; pc_nxt = {1'b0, tgt[PC_W-2:0]}; end
        9'h141: begin push = 1'b1; pc_nxt = {1'b1, tgt[PC_W-2:0]}; end
        9'h080: take = !flags_a[F_C];
        9'h082: take =  flags_a[F_C];
        9'h084: take = !flags_b[F_C];
        9'h086: take =  flags_b[F_C];
        9'h088: take = !flags_a[F_Z];
        9'h08A: take =  flags_a[F_Z];
        9'h08C: take = !flags_b[F_Z];
        9'h08E: take =  flags_b[F_Z];
        9'h090: take = !flags_a[F_V0];
        9'h092: take =  flags_a[F_V0];
        9'h094: take = !flags_b[F_V0];
        9'h096: take =  flags_b[F_V0];
        9'h098: take = !flags_a[F_V1];
        9'h09A: take =  flags_a[F_V1];
        9'h09C: take = !flags_b[F_V1];
        9'h09E: take =  flags_b[F_V1];
        9'h0A0: take = !flags_a[F_S0];
        9'h0A2: take =  flags_a[F_S0];
        9'h0A4: take = !flags_b[F_S0];
        9'h0A6: take =  flags_b[F_S0];
        9'h0A8: take = !flags_a[F_S1];
        9'h0AA: take =  flags_a[F_S1];
        9'h0AC: take = !flags_b[F_S1];
        9'h0AE: take =  flags_b[F_S1];
        9'h0B0: take = (dp_low == 4'h0);
        9'h0B1: take = (dp_low != 4'h0);
        9'h0B2: take = (dp_low == 4'hF);
        9'h0B3: take = (dp_low != 4'hF);
        9'h0BC: take = !req_flag;
        9'h0BE: take =  req_flag;
        default: take = 1'b0;
      endcase
      if (take) pc_nxt = tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      sp <= '0;
    end else begin
      pc <= pc_nxt;
      if (push)        sp <= (sp == SP_TOP) ? '0 : sp + 1'b1;
      else if (is_ret) sp <= sp_dec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && push) stk[sp] <= pc_inc;
  end

  logic            call_q;
  logic [PC_W-1:0] link_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      call_q <= 1'b0;
      link_q <= '0;
    end else begin
      call_q <= push;
      if (push) link_q <= pc_inc;
    end
  end

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_op || is_ld) |=> pc == 14'($past(pc) + 14'd1));

  // R4
  hi_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp && rom_data[21:13] == 9'h101) |=> pc[13]);

  // R4
  lo_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp && rom_data[21:13] == 9'h100) |=> !pc[13]);

  // R5
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp && rom_data[21:14] == 8'hA0) |=>
      pc[12:0] == {$past(rom_data[1:0]), $past(rom_data[12:2])});

  // R9
  no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp && rom_data[21:20] == 2'b11) |=> pc == 14'($past(pc) + 14'd1));

  // R10
  ret_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && call_q) |=> pc == $past(link_q));
endmodule

// File: tb/dsp_seq_test.sv
`timescale 1ns/1ps
module dsp_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [23:0] rom_data;
  logic [5:0]  fa, fb;
  logic [3:0]  dpl;
  logic        rq;
  logic [13:0] so;
  logic [13:0] pc;
  logic        is_op, is_ret, is_jmp, is_ld, stk_pop;

  dsp_seq uut (
    .clk(clk), .rst_n(rst_n), .rom_data(rom_data),
    .flags_a(fa), .flags_b(fb), .dp_low(dpl), .req_flag(rq), .so_val(so),
    .pc(pc), .is_op(is_op), .is_ret(is_ret), .is_jmp(is_jmp), .is_ld(is_ld),
    .stk_pop(stk_pop)
  );

  int errs = 0;
  int checks = 0;
  logic [13:0] mpc = '0;
  logic [13:0] mstk [8];
  int msp = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] ins, input logic [13:0] exp, input string tag);
    rom_data = ins;
    #1;
    chk("R2 class strobes", {28'd0, is_op, is_ret, is_jmp, is_ld}, 32'(4'b1000 >> ins[23:22]));
    chk("R10 pop strobe", {31'd0, stk_pop}, {31'd0, ins[23:22] == 2'd1});
    @(negedge clk);
    chk(tag, {18'd0, pc}, {18'd0, exp});
    mpc = exp;
  endtask

  task automatic do_jump(input logic [8:0] c, input logic [10:0] na, input logic [1:0] bk);
    logic [13:0] inc, tgt, exp;
    string tag;
    int k, f, useb, want;
    inc = mpc + 14'd1;
    tgt = {inc[13], bk, na};
    exp = inc;
    tag = "R9 no branch";
    if (c == 9'h000) begin
      exp = so; tag = "R4 serial-out load";
    end else if (c == 9'h100 || c == 9'h101) begin
      exp = {c[0], tgt[12:0]}; tag = "R4 forced page jump";
    end else if (c == 9'h140 || c == 9'h141) begin
      exp = {c[0], tgt[12:0]}; tag = "R5 call";
      mstk[msp] = inc;
      msp = (msp + 1) % 8;
    end else if (c >= 9'h080 && c <= 9'h0AE && !c[0]) begin
      k = (int'(c) - 128) / 2;
      f = k / 4;
      useb = (k / 2) % 2;
      want = k % 2;
      tag = (c == 9'h080 && mpc == 14'h1FFF) ? "R3 page from incremented pc" : "R6 flag branch";
      if ((int'((useb != 0 ? fb : fa) >> f) & 1) == want) exp = tgt;
    end else if (c >= 9'h0B0 && c <= 9'h0B3) begin
      tag = "R7 pointer nibble branch";
      case (c[1:0])
        2'd0: if (dpl == 4'h0) exp = tgt;
        2'd1: if (dpl != 4'h0) exp = tgt;
        2'd2: if (dpl == 4'hF) exp = tgt;
        default: if (dpl != 4'hF) exp = tgt;
      endcase
    end else if (c == 9'h0BC) begin
      tag = "R8 request branch"; if (!rq) exp = tgt;
    end else if (c == 9'h0BE) begin
      tag = "R8 request branch"; if (rq) exp = tgt;
    end
    step({2'd2, c, na, bk}, exp, tag);
  endtask

  task automatic do_ret();
    msp = (msp + 7) % 8;
    step({2'd1, 22'h0A5A5}, mstk[msp], "R10 return pop");
  endtask

  initial begin
    rom_data = '0; fa = '0; fb = '0; dpl = '0; rq = 1'b0; so = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", {18'd0, pc}, 32'd0);
    rst_n = 1'b1;
    mpc = '0;

    step({2'd0, 22'h12345}, 14'd1, "R2 op advance");
    step({2'd3, 22'h3ABCD}, 14'd2, "R2 load advance");

    // R2 counter wraps from 0x3FFF
    do_jump(9'h101, 11'h7FF, 2'd3);
    step({2'd0, 22'd0}, 14'd0, "R2 counter wrap");

    // R3 taken branch at 0x1FFF inherits bit 13 of the incremented value
    do_jump(9'h100, 11'h7FF, 2'd3);
    fa = 6'd0;
    do_jump(9'h080, 11'h011, 2'd1);
    chk("R3 upper page after 0x1FFF", {31'd0, pc[13]}, 32'd1);

    for (int c = 0; c < 512; c++) begin
      for (int p = 0; p < 12; p++) begin
        fa  = 6'(p * 13);
        fb  = 6'(p * 22 + 5);
        dpl = 4'(p * 5);
        rq  = ((p / 2) % 2) != 0;
        so  = 14'(c * 97 + p * 1234);
        do_jump(((c + p) % 2) != 0 ? 9'h101 : 9'h100, 11'(c * 7 + p * 3), 2'(p));
        do_jump(9'(c), 11'(c * 5 + p + 1), 2'(c + p));
      end
    end

    // R10 nine nested calls, then nine returns across the wrap
    for (int i = 0; i < 9; i++) begin
      do_jump((i % 2) != 0 ? 9'h141 : 9'h140, 11'(i * 100 + 3), 2'(i));
      step({2'd3, 22'(i)}, mpc + 14'd1, "R2 load between calls");
    end
    for (int i = 0; i < 9; i++) begin
      do_ret();
      step({2'd0, 22'(i)}, mpc + 14'd1, "R2 op between returns");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog: run still going, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule